// File: doc/BRIEF.md
# 64-bit Down-Counting Timer Channel

This block is one timer channel with a small register interface in the style of APB. Software writes a 64-bit start value into two 32-bit load registers and then sets the run bit in the control register. The channel copies the load value into a 64-bit down-counter. From then on the counter drops by one on every clock cycle in which `tick_en` is high. The counter is readable at any time as two live 32-bit halves, so a 64-bit value can be taken by reading high, low, then high again. In free-running mode the channel reloads on expiry and produces an event every load+1 ticks. Loaded with all ones, it works as a timestamp source whose bitwise inverse increases. In user-count mode the expiry fires once, and the counter then wraps to all ones and keeps counting until software stops it.

Each expiry sets a sticky status flag whatever the mask is. Writing 1 to bit 0 of the status register clears the flag. The level interrupt `irq` is the flag gated by the unmask bit. A small sequencer controls the counter and has three states. `ST_IDLE` holds the counter. `ST_COUNT` counts towards the event. `ST_OVERRUN` is user-count mode after its event. The transitions are:
- enable: `ST_IDLE` to `ST_COUNT` when the run bit is seen, loading the counter.
- free reload: `ST_COUNT` to `ST_COUNT` on a tick at zero in free mode.
- wrap: `ST_COUNT` to `ST_OVERRUN` on a tick at zero in user-count mode.
- disable: from either counting state back to `ST_IDLE` when the run bit is clear.

Top module: `tick_timer64`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The load low word (offset 0x00) and load high word (offset 0x04) are written with full 32-bit data and read back unchanged.
- R3: Writing the control register (offset 0x10) with bit 0 set, while the channel is stopped, copies the 64-bit load value into the counter on the next clock. Writing the load registers alone leaves the counter unchanged.
- R4: While running, the counter (low half at 0x08, high half at 0x0C) drops by exactly one on each cycle with `tick_en` high and holds on cycles with it low. A borrow from the low half reaches the high half in the same cycle.
- R5: While control bit 0 is clear, the counter holds its value whatever `tick_en` does.
- R6: In free-running mode (control bit 1 = 0), a tick with the counter at zero reloads the load value and sets the status flag, so events come every load+1 ticks.
- R7: In user-count mode (control bit 1 = 1), a tick with the counter at zero sets the status flag and wraps the counter to all ones. Counting continues with no further event until the channel is disabled and enabled again.
- R8: The status flag (bit 0 at 0x18) is set on expiry whatever the mask. `irq` is high only when the flag is set and control bit 2 (unmask) is 1.
- R9: Writing 1 to status bit 0 clears the flag and drops `irq`. Writing 0 leaves it unchanged.
- R10: The control register reads back only bits [2:0]. Offsets 0x14 and 0x1C read zero.
- R11: A high, low, high read of the counter returns the same high value twice when no tick falls between the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Channel selected |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` |
| tick_en | input | 1 | Counter advance strobe, one step per high cycle |
| irq | output | 1 | Level interrupt, flag AND unmask |

## Verification
Free-running mode is swept over load values 0 to 5, with the counter read after every single tick across two full periods. Getting the count right at every step tells an off-by-one period apart from a reload to the wrong value. User-count mode is swept over load values 0 to 3 past the event. This separates a wrap to all ones from a reload, and a second expiry from the required silence after the event. A load of 0x1_00000001 pushes a borrow across the word boundary and checks that the halves stay consistent. Ticks sent while the channel is stopped, and status writes of 0 versus 1, separate held state from state that was changed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_OVERRUN = 2'd2
    } run_state_e;

    // Byte offsets decoded by software drivers
    localparam logic [4:0] OFF_LOAD_LO = 5'h00;
    localparam logic [4:0] OFF_CNT_LO  = 5'h08;
    localparam logic [4:0] OFF_CTRL    = 5'h10;
    localparam logic [4:0] OFF_STAT    = 5'h18;
    localparam int         HALF_STRIDE = 4;

    typedef struct packed {
        logic unmask;     // bit 2
        logic user_mode;  // bit 1
        logic run;        // bit 0
    } ctrl_t;

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int NUM_HALVES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         expire,
    output logic [NUM_HALVES*DATA_W-1:0] load_val,
    output ctrl_t                        ctrl,
    output logic                         stat_flag
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic [DATA_W-1:0] load_q [NUM_HALVES];

    generate
        for (genvar h = 0; h < NUM_HALVES; h++) begin : g_load
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    load_q[h] <= '0;
                end else if (wr_en && addr == ADDR_W'(OFF_LOAD_LO + HALF_STRIDE*h)) begin
                    load_q[h] <= wdata;
                end
            end
            assign load_val[h*DATA_W +: DATA_W] = load_q[h];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && addr == ADDR_W'(OFF_CTRL)) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // Expiry wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_flag <= 1'b0;
        end else if (expire) begin
            stat_flag <= 1'b1;
        end else if (wr_en && addr == ADDR_W'(OFF_STAT) && wdata[0]) begin
            stat_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             user_mode,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output run_state_e       state
);

    run_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_zero;

    assign at_zero = (cnt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        expire  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    cnt_d   = load_val;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (tick_en) begin
                    if (at_zero) begin
                        expire = 1'b1;
                        if (user_mode) begin
                            cnt_d   = '1;
                            state_d = ST_OVERRUN;
                        end else begin
                            cnt_d = load_val;
                        end
                    end else begin
                        cnt_d = cnt - CNT_W'(1);
                    end
                end
            end
            ST_OVERRUN: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (tick_en) begin
                    cnt_d = cnt - CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int NUM_HALVES = 2
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_HALVES*DATA_W-1:0] load_val,
    input  logic [NUM_HALVES*DATA_W-1:0] cnt,
    input  ctrl_t                        ctrl,
    input  logic                         stat_flag,
    output logic [DATA_W-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (addr == ADDR_W'(OFF_LOAD_LO + HALF_STRIDE*h)) begin
                rdata = load_val[h*DATA_W +: DATA_W];
            end
            if (addr == ADDR_W'(OFF_CNT_LO + HALF_STRIDE*h)) begin
                rdata = cnt[h*DATA_W +: DATA_W];
            end
        end
        if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata = DATA_W'(ctrl);
        end
        if (addr == ADDR_W'(OFF_STAT)) begin
            rdata = DATA_W'(stat_flag);
        end
    end

endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
    import tmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int NUM_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              tick_en,
    output logic              irq
);

    localparam int CNT_W = NUM_HALVES * DATA_W;

    logic             wr_en;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_val;
    ctrl_t            ctrl_q;
    logic             stat_flag;
    logic             expire;
    run_state_e       run_state;
    logic             ctrl_run;
    logic             ctrl_mode;
    logic             ctrl_unmask;

    assign wr_en       = psel & penable & pwrite;
    assign ctrl_run    = ctrl_q.run;
    assign ctrl_mode   = ctrl_q.user_mode;
    assign ctrl_unmask = ctrl_q.unmask;

    tmr_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_HALVES(NUM_HALVES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
        .expire(expire), .load_val(load_val), .ctrl(ctrl_q), .stat_flag(stat_flag)
    );

    tmr_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl_run), .user_mode(ctrl_mode),
        .tick_en(tick_en), .load_val(load_val), .cnt(cnt_val), .expire(expire),
        .state(run_state)
    );

    tmr_read_mux #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_HALVES(NUM_HALVES)
    ) u_rmux (
        .addr(paddr), .load_val(load_val), .cnt(cnt_val), .ctrl(ctrl_q),
        .stat_flag(stat_flag), .rdata(prdata)
    );

    assign irq = stat_flag & ctrl_unmask;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             irq,
    input logic             run,
    input logic             mode,
    input logic             unmask,
    input logic             stat_flag,
    input logic             expire,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_val,
    input run_state_e       state
);

    p_enable_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run) |=> (cnt == $past(load_val)));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && run && tick_en && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !tick_en) |=> $stable(cnt));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !run) |=> $stable(cnt));

    p_free_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !mode) |=> (cnt == $past(load_val)));

    p_user_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode) |=> (&cnt));

    p_flag_on_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> stat_flag);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !unmask |-> !irq);

endmodule

bind tick_timer64 tmr_checker #(.CNT_W(NUM_HALVES*DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq(irq), .run(ctrl_run),
    .mode(ctrl_mode), .unmask(ctrl_unmask), .stat_flag(stat_flag),
    .expire(expire), .cnt(cnt_val), .load_val(load_val), .state(run_state)
);

// File: tb/tick_timer64_bench.sv
`timescale 1ns/1ps
module tick_timer64_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tick_timer64 u_tick_timer64 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick_en(tick_en), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic rd_cnt(output logic [63:0] v);
        logic [31:0] hi;
        logic [31:0] lo;
        rd(5'h0C, hi);
        rd(5'h08, lo);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd_irq(output logic v);
        @(negedge clk);
        #1 v = irq;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] hi2;
        logic [63:0] v;
        logic        q;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), d);
            chk("R1", "reset read", 64'(d), 64'h0);
        end
        rd_irq(q);
        chk("R1", "reset irq", 64'(q), 64'h0);

        // R2: load registers read back
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'h1234_5678);
        rd(5'h00, d); chk("R2", "load lo", 64'(d), 64'hA5A5_0F0F);
        rd(5'h04, d); chk("R2", "load hi", 64'(d), 64'h1234_5678);

        // R10: control width and unmapped offsets
        wr(5'h10, 32'hFFFF_FFF8);
        rd(5'h10, d); chk("R10", "ctrl upper bits", 64'(d), 64'h0);
        rd(5'h14, d); chk("R10", "gap 0x14", 64'(d), 64'h0);
        rd(5'h1C, d); chk("R10", "gap 0x1C", 64'(d), 64'h0);

        // R3: load alone does not touch counter, enable copies it
        rd_cnt(v); chk("R3", "count before enable", v, 64'h0);
        wr(5'h10, 32'h1);
        rd_cnt(v); chk("R3", "count after enable", v, 64'h1234_5678_A5A5_0F0F);
        rd(5'h10, d); chk("R10", "ctrl readback", 64'(d), 64'h1);

        // R4 / R11: borrow across halves
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h1);
        wr(5'h04, 32'h1);
        wr(5'h10, 32'h1);
        ticks(1);
        rd_cnt(v); chk("R4", "one tick", v, 64'h1_0000_0000);
        ticks(1);
        rd(5'h0C, d);
        rd(5'h08, hi2);
        v = {d, hi2};
        rd(5'h0C, hi2);
        chk("R4", "borrow", v, 64'h0_FFFF_FFFF);
        chk("R11", "high stable", 64'(hi2), 64'(d));
        wr(5'h10, 32'h0);

        // R5: stopped counter ignores ticks
        ticks(4);
        rd_cnt(v); chk("R5", "hold when stopped", v, 64'h0_FFFF_FFFF);

        // R6 / R4 / R8: free-running sweep, unmasked
        for (int L = 0; L <= 5; L++) begin
            wr(5'h10, 32'h0);
            wr(5'h18, 32'h1);
            wr(5'h00, 32'(L));
            wr(5'h04, 32'h0);
            wr(5'h10, 32'h5);
            rd(5'h18, d); chk("R6", "flag before event", 64'(d), 64'h0);
            for (int k = 1; k <= 2 * (L + 1); k++) begin
                ticks(1);
                rd_cnt(v);
                chk("R6", "free count", v, 64'(L - (k % (L + 1))));
                rd(5'h18, d);
                chk("R6", "free flag", 64'(d), 64'(k >= L + 1));
                rd_irq(q);
                chk("R8", "irq unmasked", 64'(q), 64'(k >= L + 1));
            end
        end

        // R9: status clear
        wr(5'h18, 32'h0);
        rd(5'h18, d); chk("R9", "write 0 keeps flag", 64'(d), 64'h1);
        rd_irq(q); chk("R9", "irq kept", 64'(q), 64'h1);
        wr(5'h10, 32'h4);
        wr(5'h18, 32'h1);
        rd(5'h18, d); chk("R9", "write 1 clears flag", 64'(d), 64'h0);
        rd_irq(q); chk("R9", "irq dropped", 64'(q), 64'h0);

        // R7 / R8: user-count sweep, masked
        for (int L = 0; L <= 3; L++) begin
            wr(5'h10, 32'h0);
            wr(5'h18, 32'h1);
            wr(5'h00, 32'(L));
            wr(5'h04, 32'h0);
            wr(5'h10, 32'h3);
            for (int k = 1; k <= L + 3; k++) begin
                logic [63:0] e;
                ticks(1);
                if (k <= L) e = 64'(L - k);
                else        e = 64'hFFFF_FFFF_FFFF_FFFF - 64'(k - L - 1);
                rd_cnt(v);
                chk("R7", "user count", v, e);
                rd(5'h18, d);
                chk("R8", "flag while masked", 64'(d), 64'(k >= L + 1));
                rd_irq(q);
                chk("R8", "irq masked", 64'(q), 64'h0);
            end
            wr(5'h18, 32'h1);
            ticks(3);
            rd(5'h18, d); chk("R7", "no second event", 64'(d), 64'h0);
        end

        // R8: unmasking a pending flag raises irq
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h10, 32'h3);
        ticks(1);
        rd_irq(q); chk("R8", "masked pending", 64'(q), 64'h0);
        wr(5'h10, 32'h7);
        rd_irq(q); chk("R8", "unmasked pending", 64'(q), 64'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule